// File: doc/BRIEF.md
# Power-Manager Interrupt Aggregator With Wakeup

This block gathers the power-management events that concern one processor and presents them on a single interrupt line. Three events are tracked:

- a peripheral-group wake-up;
- the completion of a forced wake-up transition on the processor's domain, which another processor may start;
- a PLL recalibration request.

Each event sets its own sticky status bit. An enable register masks each bit independently. Software reads the status register to find the cause and clears a bit by writing 1 to it.

The same enabled events also produce a wake-up request toward the processor's power domain while that domain is idle. This lets a sleeping domain be revived by the event it is waiting for.

The recalibration request is a level. The PLL holds it high until it has been reinitialised, so its status bit comes back every cycle the level stays high.

Access is through a small register port. Writes take effect on the clock edge. The read data is a combinational function of the address.

Top module: `pm_irq_wake_agg`

## Requirements
- R1: While reset is held and after it is released, the enable register, status register, interrupt and wake-up outputs are all zero.
- R2: Address 0 is the enable register: a write stores wdata bits [2:0], and a read returns them with all upper bits zero. Address 1 is the status register. Any other address reads zero and writes to it change nothing.
- R3: Status bit 0 (peripheral wake pulse), bit 1 (force-wake-complete pulse) and bit 2 (recalibration level) set on the clock edge where their input is high. They are reported whatever the enable bits hold.
- R4: Writing 1 to a status bit clears it on that edge. Writing 0 leaves it unchanged.
- R5: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R6: While the recalibration input stays high, status bit 2 is set again on every edge, so a clearing write does not remove it.
- R7: The interrupt output is high exactly when some status bit and its matching enable bit are both 1.
- R8: The wake-up output is high exactly when the interrupt condition holds and the domain-idle input is high. It falls in the same cycle that the idle input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 enable, 1 status) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| ev_periph_wake | input | 1 | Peripheral-group wake-up pulse |
| ev_force_wake_done | input | 1 | Forced wake-up transition complete pulse |
| ev_pll_recal | input | 1 | PLL recalibration request level |
| dom_idle | input | 1 | Processor power domain is idle |
| irq | output | 1 | Interrupt line |
| wake_req | output | 1 | Wake-up request for the idle domain |

## Verification
The main function is swept over every combination of enable mask, event pattern and idle level. That sweep shows that status follows the raw events whatever the mask holds, and that only the interrupt and wake-up outputs depend on the mask and the idle input.

Directed patterns cover the remaining cases:
- an event arriving together with a clearing write on the same bit, which separates set-wins from clear-wins;
- a held recalibration level against a pulse, which tells level re-arming from one-shot latching;
- writes of 0 and writes to unused addresses, which show that only 1-bits at the status address clear anything.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int NSRC = 3;
  localparam int SRC_PERIPH = 0;
  localparam int SRC_FWAKE  = 1;
  localparam int SRC_RECAL  = 2;
  localparam int ADDR_ENABLE = 0;
  localparam int ADDR_STATUS = 1;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_irq_status_bank.sv
module pm_irq_status_bank
  import pm_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  logic     clr_wr_i,
  input  src_vec_t clr_mask_i,
  output src_vec_t status_o
);
  src_vec_t status_q, status_d;
  logic     upd_en;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      status_d[i] = status_q[i];
      if (clr_wr_i && clr_mask_i[i]) status_d[i] = 1'b0;
      if (set_i[i])                  status_d[i] = 1'b1;
    end
  end

  assign upd_en = clr_wr_i || (|set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/pm_irq_enable_reg.sv
module pm_irq_enable_reg
  import pm_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  src_vec_t data_i,
  output src_vec_t enable_o
);
  src_vec_t enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    enable_q <= '0;
    else if (wr_i) enable_q <= data_i;
  end

  assign enable_o = enable_q;
endmodule

// File: rtl/pm_irq_gate.sv
module pm_irq_gate
  import pm_irq_pkg::*;
(
  input  src_vec_t status_i,
  input  src_vec_t enable_i,
  input  logic     idle_i,
  output logic     irq_o,
  output logic     wake_o
);
  src_vec_t pending;

  always_comb begin
    pending = status_i & enable_i;
    irq_o   = |pending;
    wake_o  = irq_o && idle_i;
  end
endmodule

// File: rtl/pm_irq_wake_agg.sv
module pm_irq_wake_agg
  import pm_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_periph_wake,
  input  logic              ev_force_wake_done,
  input  logic              ev_pll_recal,
  input  logic              dom_idle,
  output logic              irq,
  output logic              wake_req
);
  localparam int PAD_W = DATA_W - NSRC;

  logic     rst_sync_n;
  logic     sel_en, sel_st;
  src_vec_t ev_vec;
  src_vec_t enable_q;
  src_vec_t status_q;
  src_vec_t rd_vec;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel_en = (reg_addr == ADDR_W'(ADDR_ENABLE));
    sel_st = (reg_addr == ADDR_W'(ADDR_STATUS));
    ev_vec = '0;
    ev_vec[SRC_PERIPH] = ev_periph_wake;
    ev_vec[SRC_FWAKE]  = ev_force_wake_done;
    ev_vec[SRC_RECAL]  = ev_pll_recal;
  end

  pm_irq_enable_reg u_en (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_i     (reg_wr && sel_en),
    .data_i   (reg_wdata[NSRC-1:0]),
    .enable_o (enable_q)
  );

  pm_irq_status_bank u_st (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_i      (ev_vec),
    .clr_wr_i   (reg_wr && sel_st),
    .clr_mask_i (reg_wdata[NSRC-1:0]),
    .status_o   (status_q)
  );

  pm_irq_gate u_gate (
    .status_i (status_q),
    .enable_i (enable_q),
    .idle_i   (dom_idle),
    .irq_o    (irq),
    .wake_o   (wake_req)
  );

  always_comb begin
    rd_vec = '0;
    if (sel_en) rd_vec = enable_q;
    if (sel_st) rd_vec = status_q;
  end

  if (PAD_W > 0) begin : g_pad
    assign reg_rdata = {{PAD_W{1'b0}}, rd_vec};
  end else begin : g_nopad
    assign reg_rdata = rd_vec;
  end
endmodule

// File: rtl/pm_irq_wake_agg_chk.sv
module pm_irq_wake_agg_chk
  import pm_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input src_vec_t          ev_vec,
  input src_vec_t          enable_q,
  input src_vec_t          status_q,
  input logic              dom_idle,
  input logic              irq,
  input logic              wake_req
);
  logic st_wr;
  assign st_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_STATUS));

  // R1: state is zero while held in reset
  always_comb begin
    if (!rst_sync_n) begin
      a_r1_reset_clear: assert (status_q == '0 && enable_q == '0);
    end
  end

  // R3, R5: every raised event appears in status on the next edge
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_vec != '0) |=> ((status_q & $past(ev_vec)) == $past(ev_vec)));

  // R4: with no clearing write, no status bit is lost
  a_r4_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !st_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4: a clearing write with no events removes the written bits
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_wr && ev_vec == '0) |=> ((status_q & $past(reg_wdata[NSRC-1:0])) == '0));

  // R6: a held recalibration level keeps bit 2 set
  a_r6_recal_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_vec[SRC_RECAL] |=> status_q[SRC_RECAL]);

  // R7: an enabled event raises the interrupt on the next cycle when the mask is unchanged
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (((ev_vec & enable_q) != '0) && !reg_wr) |=> irq);

  // R8: wake-up only while idle and interrupting
  a_r8_wake_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_req |-> (dom_idle && irq));
endmodule

bind pm_irq_wake_agg pm_irq_wake_agg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .ev_vec     (ev_vec),
  .enable_q   (enable_q),
  .status_q   (status_q),
  .dom_idle   (dom_idle),
  .irq        (irq),
  .wake_req   (wake_req)
);

// File: tb/pm_irq_wake_agg_tb.sv
module pm_irq_wake_agg_tb;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              ev_pw, ev_fw, ev_rc, dom_idle;
  logic              irq, wake_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pm_irq_wake_agg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk                (clk),
    .rst_n              (rst_n),
    .reg_wr             (reg_wr),
    .reg_addr           (reg_addr),
    .reg_wdata          (reg_wdata),
    .reg_rdata          (reg_rdata),
    .ev_periph_wake     (ev_pw),
    .ev_force_wake_done (ev_fw),
    .ev_pll_recal       (ev_rc),
    .dom_idle           (dom_idle),
    .irq                (irq),
    .wake_req           (wake_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int addr, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = DATA_W'(data);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input int addr, output int data);
    reg_addr = ADDR_W'(addr);
    #1;
    data = int'(reg_rdata);
  endtask

  task automatic pulse_events(input int ev);
    @(negedge clk);
    ev_pw = ev[0]; ev_fw = ev[1]; ev_rc = ev[2];
    @(negedge clk);
    ev_pw = 1'b0; ev_fw = 1'b0; ev_rc = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, exp_irq;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ev_pw = 1'b0; ev_fw = 1'b0; ev_rc = 1'b0; dom_idle = 1'b0;
    repeat (3) @(negedge clk);
    rd_reg(0, v); check(v == 0, "R1 enable in reset", v, 0);
    rd_reg(1, v); check(v == 0, "R1 status in reset", v, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(0, v); check(v == 0, "R1 enable after reset", v, 0);
    rd_reg(1, v); check(v == 0, "R1 status after reset", v, 0);
    check(irq == 0 && wake_req == 0, "R1 outputs after reset", int'(irq), 0);

    // R2 upper bits dropped, unused address
    wr_reg(0, 8'hFD);
    rd_reg(0, v); check(v == 5, "R2 enable upper bits zero", v, 5);
    wr_reg(2, 8'hFF);
    rd_reg(2, v); check(v == 0, "R2 unused address reads zero", v, 0);
    rd_reg(0, v); check(v == 5, "R2 unused write ignored", v, 5);

    // R3, R7, R8 exhaustive sweep
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        for (int idl = 0; idl < 2; idl++) begin
          wr_reg(0, en);
          wr_reg(1, 7);
          dom_idle = idl[0];
          pulse_events(ev);
          rd_reg(0, v); check(v == en, "R2 enable readback", v, en);
          rd_reg(1, v); check(v == ev, "R3 raw status", v, ev);
          exp_irq = ((ev & en) != 0) ? 1 : 0;
          check(int'(irq) == exp_irq, "R7 irq", int'(irq), exp_irq);
          check(int'(wake_req) == (exp_irq & idl), "R8 wake", int'(wake_req), exp_irq & idl);
          wr_reg(1, 7);
          rd_reg(1, v); check(v == 0, "R4 clear all", v, 0);
          check(irq == 0, "R7 irq after clear", int'(irq), 0);
        end
      end
    end

    // R4 write zero leaves bits
    wr_reg(0, 7);
    pulse_events(3);
    wr_reg(1, 0);
    rd_reg(1, v); check(v == 3, "R4 write zero no effect", v, 3);
    wr_reg(1, 1);
    rd_reg(1, v); check(v == 2, "R4 partial clear", v, 2);
    wr_reg(1, 7);

    // R5 set wins over clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(1); reg_wdata = 8'h01; ev_pw = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_pw = 1'b0;
    rd_reg(1, v); check(v == 1, "R5 set wins", v, 1);
    wr_reg(1, 7);

    // R6 held recalibration level
    dom_idle = 1'b1;
    @(negedge clk); ev_rc = 1'b1;
    @(negedge clk);
    wr_reg(1, 4);
    rd_reg(1, v); check(v == 4, "R6 recal rearms", v, 4);
    check(wake_req == 1, "R8 wake with recal idle", int'(wake_req), 1);
    dom_idle = 1'b0; #1;
    check(wake_req == 0, "R8 wake drops leaving idle", int'(wake_req), 0);
    check(irq == 1, "R7 irq stays", int'(irq), 1);
    @(negedge clk); ev_rc = 1'b0;
    wr_reg(1, 4);
    rd_reg(1, v); check(v == 0, "R6 clears after level drops", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule